// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block sends bytes on an asynchronous serial line. Software writes a byte into a one-entry holding register. As soon as the shift register is free, the block copies the byte into it. It then sends a frame made of a low start bit, eight data bits with the least significant bit first, an optional parity bit, and a high stop bit. Each bit lasts one period of an external baud tick, and the line rests high when nothing is being sent.

Because the holding register can be refilled while a frame is still leaving the shifter, software can keep the line busy with frames sent back to back and no idle gap between them. The block has three status flags:
- buffer-empty, which is live and means a new byte may be written;
- busy, which is live and covers the time a frame is on the line;
- transmit-end, which is sticky and is set only when a stop bit finishes with no byte waiting.

Software clears transmit-end by writing 1 to it. An interrupt request combines the two reportable flags, each gated by its own enable.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset the line is high, buffer-empty is 1, busy is 0, transmit-end is 0 and no frame is sent.
- R2: A pulse on `wrData` clears buffer-empty on the next cycle. When the shifter is idle, the byte moves into it one cycle later and buffer-empty returns to 1.
- R3: Busy rises on the same clock edge that drives the start bit (line low) and stays 1 until the last stop bit ends. It changes only on cycles where `baudTick` is 1.
- R4: A frame is 0 (start), then data bit 0 through data bit 7, then the parity bit if enabled, then 1 (stop). Each bit lasts exactly one baud-tick period, and the first bit begins on the first tick after the transfer. The line is 1 whenever busy is 0.
- R5: When `parityOn` is 1, a parity bit follows bit 7. With `parityOdd` = 0 the count of ones over the data and parity bits is even; with `parityOdd` = 1 it is odd. Both settings are taken at the moment of the transfer.
- R6: If a byte is waiting when a stop bit ends, the next start bit begins on that same tick. Busy stays 1 and transmit-end is not set.
- R7: If no byte is waiting when a stop bit ends, busy falls to 0 and transmit-end rises to 1 on the same edge.
- R8: A pulse on `clrDone` clears transmit-end on the next cycle. If transmit-end is being set in that same cycle, the set wins.
- R9: `irq` is 1 exactly when (buffer-empty AND `ieEmpty`) OR (transmit-end AND `ieDone`).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrData | input | 1 | Write strobe for the holding register |
| wrByte | input | 8 | Byte to transmit |
| clrDone | input | 1 | Write-1 clear of the transmit-end flag |
| baudTick | input | 1 | One-cycle pulse marking each bit boundary |
| parityOn | input | 1 | Add a parity bit to the frame |
| parityOdd | input | 1 | 1 selects odd parity, 0 selects even parity |
| ieEmpty | input | 1 | Interrupt enable for buffer-empty |
| ieDone | input | 1 | Interrupt enable for transmit-end |
| txLine | output | 1 | Serial output line |
| bufEmpty | output | 1 | Holding register can accept a byte |
| txBusy | output | 1 | A frame is on the line |
| txDone | output | 1 | Sticky transmit-end flag |
| irq | output | 1 | Interrupt request |

## Verification
Two events can fall in the same cycle: the stop-bit tick that sets transmit-end and a software clear of that flag. The bench raises `clrDone` on exactly the cycle where the reference model shows the final stop bit ending on a tick. It then expects transmit-end to read 1 afterwards, and checks that a later clear on its own does drop the flag. A second overlap is a refill written while a frame is still shifting. For that case the bench counts cycles in which busy is low before transmit-end rises, and expects zero.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [1:0] {
    DRV_MARK,
    DRV_START,
    DRV_DATA,
    DRV_PAR
  } drvSel_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } txState_t;

  typedef struct packed {
    logic    loadShift;
    logic    shiftNext;
    logic    setDone;
    drvSel_t drive;
  } txStrb_t;

endpackage

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    baudTick,
  input  logic    holdFull,
  input  logic    parEn,
  output txStrb_t strb,
  output logic    txBusy
);

  localparam int CNT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_BITS - 1);

  txState_t state, stateNxt;
  logic [CNT_W-1:0] bitCnt, bitCntNxt;

  always_comb begin
    stateNxt       = state;
    bitCntNxt      = bitCnt;
    strb.loadShift = 1'b0;
    strb.shiftNext = 1'b0;
    strb.setDone   = 1'b0;
    strb.drive     = DRV_MARK;
    case (state)
      ST_IDLE: begin
        if (holdFull) begin
          strb.loadShift = 1'b1;
          stateNxt       = ST_ARM;
        end
      end
      ST_ARM: begin
        if (baudTick) stateNxt = ST_START;
      end
      ST_START: begin
        strb.drive = DRV_START;
        if (baudTick) begin
          stateNxt  = ST_DATA;
          bitCntNxt = '0;
        end
      end
      ST_DATA: begin
        strb.drive = DRV_DATA;
        if (baudTick) begin
          strb.shiftNext = 1'b1;
          if (bitCnt == LAST_BIT) stateNxt = parEn ? ST_PAR : ST_STOP;
          else bitCntNxt = bitCnt + 1'b1;
        end
      end
      ST_PAR: begin
        strb.drive = DRV_PAR;
        if (baudTick) stateNxt = ST_STOP;
      end
      ST_STOP: begin
        if (baudTick) begin
          if (holdFull) begin
            strb.loadShift = 1'b1;
            stateNxt       = ST_START;
          end else begin
            strb.setDone = 1'b1;
            stateNxt     = ST_IDLE;
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state  <= stateNxt;
      bitCnt <= bitCntNxt;
    end
  end

  assign txBusy = (state == ST_START) || (state == ST_DATA) ||
                  (state == ST_PAR)   || (state == ST_STOP);

endmodule

// File: rtl/uart_tx_datapath.sv
module uart_tx_datapath
  import uart_tx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrData,
  input  logic [DATA_BITS-1:0] wrByte,
  input  logic                 parityOn,
  input  logic                 parityOdd,
  input  txStrb_t              strb,
  output logic                 holdFull,
  output logic                 parEn,
  output logic                 txLine
);

  logic [DATA_BITS-1:0] holdByte;
  logic [DATA_BITS-1:0] shReg;
  logic                 parBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdFull <= 1'b0;
      holdByte <= '0;
    end else begin
      if (wrData) begin
        holdFull <= 1'b1;
        holdByte <= wrByte;
      end else if (strb.loadShift) begin
        holdFull <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      parBit <= 1'b0;
      parEn  <= 1'b0;
    end else if (strb.loadShift) begin
      shReg  <= holdByte;
      parBit <= (^holdByte) ^ parityOdd;
      parEn  <= parityOn;
    end else if (strb.shiftNext) begin
      shReg  <= {1'b0, shReg[DATA_BITS-1:1]};
    end
  end

  always_comb begin
    case (strb.drive)
      DRV_START: txLine = 1'b0;
      DRV_DATA:  txLine = shReg[0];
      DRV_PAR:   txLine = parBit;
      default:   txLine = 1'b1;
    endcase
  end

endmodule

// File: rtl/uart_tx_flags.sv
module uart_tx_flags (
  input  logic clk,
  input  logic rstN,
  input  logic setDone,
  input  logic clrDone,
  input  logic holdFull,
  input  logic ieEmpty,
  input  logic ieDone,
  output logic bufEmpty,
  output logic txDone,
  output logic irq
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        txDone <= 1'b0;
    else if (setDone) txDone <= 1'b1;
    else if (clrDone) txDone <= 1'b0;
  end

  assign bufEmpty = ~holdFull;
  assign irq      = (bufEmpty & ieEmpty) | (txDone & ieDone);

endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
  import uart_tx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrData,
  input  logic [DATA_BITS-1:0] wrByte,
  input  logic                 clrDone,
  input  logic                 baudTick,
  input  logic                 parityOn,
  input  logic                 parityOdd,
  input  logic                 ieEmpty,
  input  logic                 ieDone,
  output logic                 txLine,
  output logic                 bufEmpty,
  output logic                 txBusy,
  output logic                 txDone,
  output logic                 irq
);

  txStrb_t strb;
  logic    holdFull;
  logic    parEn;

  uart_tx_ctrl #(.DATA_BITS(DATA_BITS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .baudTick (baudTick),
    .holdFull (holdFull),
    .parEn    (parEn),
    .strb     (strb),
    .txBusy   (txBusy)
  );

  uart_tx_datapath #(.DATA_BITS(DATA_BITS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .wrData    (wrData),
    .wrByte    (wrByte),
    .parityOn  (parityOn),
    .parityOdd (parityOdd),
    .strb      (strb),
    .holdFull  (holdFull),
    .parEn     (parEn),
    .txLine    (txLine)
  );

  uart_tx_flags u_flags (
    .clk      (clk),
    .rstN     (rstN),
    .setDone  (strb.setDone),
    .clrDone  (clrDone),
    .holdFull (holdFull),
    .ieEmpty  (ieEmpty),
    .ieDone   (ieDone),
    .bufEmpty (bufEmpty),
    .txDone   (txDone),
    .irq      (irq)
  );

endmodule

// File: rtl/uart_tx_dbuf_chk.sv
module uart_tx_dbuf_chk (
  input logic clk,
  input logic rstN,
  input logic wrData,
  input logic clrDone,
  input logic baudTick,
  input logic ieDone,
  input logic txLine,
  input logic bufEmpty,
  input logic txBusy,
  input logic txDone,
  input logic irq
);

  p_write_fills_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrData |=> !bufEmpty);

  p_start_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txBusy) |-> !txLine);

  p_busy_on_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
    !baudTick |=> $stable(txBusy));

  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txLine);

  p_done_at_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txDone) |-> $fell(txBusy));

  p_clear_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (clrDone && !txBusy) |=> !txDone);

  p_irq_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    (txDone && ieDone) |-> irq);

endmodule

bind uart_tx_dbuf uart_tx_dbuf_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrData   (wrData),
  .clrDone  (clrDone),
  .baudTick (baudTick),
  .ieDone   (ieDone),
  .txLine   (txLine),
  .bufEmpty (bufEmpty),
  .txBusy   (txBusy),
  .txDone   (txDone),
  .irq      (irq)
);

// File: tb/tb_uart_tx_dbuf.sv
`timescale 1ns/100ps
module tb_uart_tx_dbuf;

  localparam int TDIV = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrData = 1'b0;
  logic [7:0] wrByte = '0;
  logic clrDone = 1'b0;
  logic baudTick = 1'b0;
  logic parityOn = 1'b0;
  logic parityOdd = 1'b0;
  logic ieEmpty = 1'b0;
  logic ieDone = 1'b0;
  logic txLine, bufEmpty, txBusy, txDone, irq;

  int total = 0;
  int bad = 0;
  int divCnt = 0;
  bit cmpOn = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  uart_tx_dbuf dut (
    .clk(clk), .rstN(rstN), .wrData(wrData), .wrByte(wrByte),
    .clrDone(clrDone), .baudTick(baudTick), .parityOn(parityOn),
    .parityOdd(parityOdd), .ieEmpty(ieEmpty), .ieDone(ieDone),
    .txLine(txLine), .bufEmpty(bufEmpty), .txBusy(txBusy),
    .txDone(txDone), .irq(irq)
  );

  // baud tick: one cycle high every TDIV cycles
  always @(negedge clk) begin
    divCnt   <= (divCnt == TDIV - 1) ? 0 : divCnt + 1;
    baudTick <= (divCnt == TDIV - 2);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // reference model: frame as a queue of line levels
  int   mState;      // 0 idle, 1 waiting first tick, 2 sending
  bit   mq[$];
  logic mFull;
  logic [7:0] mByte;
  logic mDone;

  always @(posedge clk) begin
    bit doLoad;
    bit doSet;
    doLoad = 0;
    doSet  = 0;
    if (!rstN) begin
      mState = 0; mq.delete(); mFull = 0; mDone = 0; mByte = '0;
    end else begin
      case (mState)
        0: if (mFull) begin doLoad = 1; mState = 1; end
        1: if (baudTick) mState = 2;
        default: if (baudTick) begin
          void'(mq.pop_front());
          if (mq.size() == 0) begin
            if (mFull) doLoad = 1;
            else begin mState = 0; doSet = 1; end
          end
        end
      endcase
      if (doLoad) begin
        mq.delete();
        mq.push_back(1'b0);
        for (int i = 0; i < 8; i++) mq.push_back(mByte[i]);
        if (parityOn) mq.push_back((^mByte) ^ parityOdd);
        mq.push_back(1'b1);
      end
      if (wrData) begin mFull = 1; mByte = wrByte; end
      else if (doLoad) mFull = 0;
      if (doSet) mDone = 1;
      else if (clrDone) mDone = 0;
    end
  end

  always @(negedge clk) begin
    if (rstN && cmpOn) begin
      logic eLine, eBusy, eIrq;
      eBusy = (mState == 2);
      eLine = eBusy ? mq[0] : 1'b1;
      eIrq  = (!mFull && ieEmpty) || (mDone && ieDone);
      chk(txLine === eLine, "R4 line level", txLine, eLine);
      chk(bufEmpty === !mFull, "R2 buffer-empty", bufEmpty, !mFull);
      chk(txBusy === eBusy, "R3 busy", txBusy, eBusy);
      chk(txDone === mDone, "R7 transmit-end", txDone, mDone);
      chk(irq === eIrq, "R9 irq", irq, eIrq);
    end
  end

  task automatic writeByte(input logic [7:0] b);
    @(negedge clk); #1;
    wrData = 1'b1; wrByte = b;
    @(negedge clk); #1;
    wrData = 1'b0;
  endtask

  task automatic captureFrame(input int nBits, output logic [10:0] bits);
    bits = '1;
    do @(negedge clk); while (txLine !== 1'b0);
    repeat (2) @(negedge clk);
    bits[0] = txLine;
    for (int i = 1; i < nBits; i++) begin
      repeat (TDIV) @(negedge clk);
      bits[i] = txLine;
    end
  endtask

  task automatic waitDone();
    int n;
    n = 0;
    while (txDone !== 1'b1 && n < 500) begin @(negedge clk); n++; end
  endtask

  task automatic pulseClear();
    @(negedge clk); #1; clrDone = 1'b1;
    @(negedge clk); #1; clrDone = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finishRun();
  end

  initial begin
    logic [10:0] fr;
    int gaps;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(txLine === 1'b1, "R1 line idle", txLine, 1);
    chk(bufEmpty === 1'b1, "R1 buffer-empty", bufEmpty, 1);
    chk(txBusy === 1'b0, "R1 busy", txBusy, 0);
    chk(txDone === 1'b0, "R1 transmit-end", txDone, 0);
    #1; rstN = 1'b1; cmpOn = 1;
    ieEmpty = 1'b1; ieDone = 1'b1;

    // R2 write then transfer
    @(negedge clk); #1; wrData = 1'b1; wrByte = 8'hA5;
    @(negedge clk);
    chk(bufEmpty === 1'b0, "R2 filled after write", bufEmpty, 0);
    #1; wrData = 1'b0;
    @(negedge clk);
    chk(bufEmpty === 1'b1, "R2 transfer to shifter", bufEmpty, 1);

    // R4 frame without parity, LSB first
    captureFrame(10, fr);
    chk(fr[9:0] === {1'b1, 8'hA5, 1'b0}, "R4 frame bits", fr[9:0], {1'b1, 8'hA5, 1'b0});
    waitDone();
    chk(txDone === 1'b1 && txBusy === 1'b0, "R7 end of frame", {txDone, txBusy}, 2'b10);
    pulseClear();
    @(negedge clk);
    chk(txDone === 1'b0, "R8 clear", txDone, 0);

    // R5 even parity
    parityOn = 1'b1; parityOdd = 1'b0;
    writeByte(8'h07);
    captureFrame(11, fr);
    chk(fr[8:1] === 8'h07, "R5 data under even", fr[8:1], 8'h07);
    chk(fr[9] === 1'b1, "R5 even parity bit", fr[9], 1);
    chk(fr[10] === 1'b1, "R4 stop after parity", fr[10], 1);
    waitDone(); pulseClear();

    // R5 odd parity
    parityOdd = 1'b1;
    writeByte(8'h03);
    captureFrame(11, fr);
    chk($countones(fr[9:1]) % 2 == 1, "R5 odd count", $countones(fr[9:1]), 3);
    waitDone(); pulseClear();
    parityOn = 1'b0; parityOdd = 1'b0;

    // R6 back to back, no gap
    writeByte(8'h11);
    while (bufEmpty !== 1'b1) @(negedge clk);
    writeByte(8'h22);
    while (txBusy !== 1'b1) @(negedge clk);
    gaps = 0;
    while (txDone !== 1'b1) begin
      @(negedge clk);
      if (txBusy !== 1'b1 && txDone !== 1'b1) gaps++;
    end
    chk(gaps == 0, "R6 idle cycles between frames", gaps, 0);

    // R8 set and clear in same cycle: set wins
    writeByte(8'h5A);
    forever begin
      @(negedge clk); #1;
      if (mState == 2 && mq.size() == 1 && baudTick) break;
    end
    clrDone = 1'b1;
    @(negedge clk);
    chk(txDone === 1'b1, "R8 set beats clear", txDone, 1);
    #1; clrDone = 1'b0;

    // R9 irq enables
    ieEmpty = 1'b0; ieDone = 1'b0;
    @(negedge clk);
    chk(irq === 1'b0, "R9 both disabled", irq, 0);
    #1; ieDone = 1'b1;
    @(negedge clk);
    chk(irq === 1'b1, "R9 done enabled", irq, 1);
    #1; ieDone = 1'b0; ieEmpty = 1'b1;
    @(negedge clk);
    chk(irq === 1'b1, "R9 empty enabled", irq, 1);
    pulseClear();
    @(negedge clk);
    chk(txDone === 1'b0, "R8 clear alone", txDone, 0);
    repeat (5) @(negedge clk);
    finishRun();
  end

endmodule